// File: doc/BRIEF.md
# UART Receive Status Flag Unit

This block keeps the receive-side status of a UART between the serial receive logic and a register read port. The receiver sends it one-cycle event pulses: a character was completed, with framing error, parity error, break and address-bit qualifiers, plus an idle-line pulse. The unit turns these pulses into sticky flags. A read of the receive buffer clears the flags. The block also tracks whether the buffer still holds an unread character, so that it can flag an overrun.

The 16-bit status word also reports an aggregate error bit and a live busy bit from the transmitter and receiver. It carries a loopback control that can only be changed while the UART is in software reset. When loopback is on, the unit steers the transmit line into the receiver input. Software polls the status word and reads the buffer after each character. The receiver drives the event inputs.

Top module: `uart_rx_status`

## Requirements
- R1: After rst_n is released, status is 16'h0000 and loop_en is 0.
- R2: Bits 15 to 8 of status always read 0.
- R3: status[0] (busy) equals tx_busy OR rx_busy in the same cycle, and no write changes it.
- R4: status[7] and loop_en hold the loopback setting. It takes wr_loop on a clock edge where wr_en and sw_reset are both 1. A write while sw_reset is 0 is ignored.
- R5: rx_line equals tx_line while loopback is on, and rx_pin otherwise.
- R6: status[6] (framing) is set in the cycle after char_done together with frame_err. It stays set until a buffer read.
- R7: status[5] (overrun) is set after a char_done that arrives while an earlier character is still unread and no buffer read happens in that cycle. An unread character exists from a char_done until the next rd_buf.
- R8: status[4] (parity) is set after char_done with par_err while par_en is 1. It reads 0 in any cycle where par_en is 0.
- R9: status[3] (break) is set in the cycle after char_done with brk_det.
- R10: status[2] (receive error) is set in the cycle after a character that sets framing, overrun, or parity with par_en = 1.
- R11: With mp_addr = 1, status[1] is set by char_done with addr_idle. With mp_addr = 0, status[1] is set by any addr_idle pulse, whether or not char_done is present.
- R12: rd_buf clears status[6:1] and the unread state. When rd_buf and char_done occur in the same cycle, status[6:1] afterwards describe only the new character and no overrun is flagged.
- R13: While sw_reset is 1, status[6:1] and the unread state are cleared on every edge. Loopback keeps its value unless it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_done | input | 1 | Pulse: a character has been moved into the receive buffer |
| frame_err | input | 1 | Qualifier of char_done: stop bit was low |
| par_err | input | 1 | Qualifier of char_done: parity mismatch |
| brk_det | input | 1 | Qualifier of char_done: break condition |
| addr_idle | input | 1 | Address-bit qualifier (address mode) or idle-line pulse (idle mode) |
| par_en | input | 1 | Parity checking enabled |
| mp_addr | input | 1 | Multiprocessor mode: 1 address-bit, 0 idle-line |
| rd_buf | input | 1 | Pulse: receive buffer is being read |
| tx_busy | input | 1 | Transmitter active |
| rx_busy | input | 1 | Receiver active |
| sw_reset | input | 1 | Software reset level |
| wr_en | input | 1 | Status register write strobe |
| wr_loop | input | 1 | Write value for the loopback field |
| tx_line | input | 1 | Transmit serial line |
| rx_pin | input | 1 | External receive serial line |
| status | output | 16 | Status word |
| loop_en | output | 1 | Loopback enabled |
| rx_line | output | 1 | Serial input presented to the receiver |

## Verification
The key collision is a buffer read in the same cycle as a new character. The new character's flags must win, with overrun suppressed. In idle-line mode the collision is a read together with an idle pulse, and the pulse must survive the read. Random phases with high read and character rates make these collisions frequent. A bench model that clears on the read and then applies the events judges every flag on the following cycle. Software reset held together with events is also provoked, and the model expects the reset to override them.

// File: rtl/usts_pkg.sv
package usts_pkg;
    localparam int STAT_W   = 16;
    localparam int LOW_W    = 8;
    localparam int B_LOOP   = 7;
    localparam int B_FRAME  = 6;
    localparam int B_OVR    = 5;
    localparam int B_PAR    = 4;
    localparam int B_BRK    = 3;
    localparam int B_ERR    = 2;
    localparam int B_ADDR   = 1;
    localparam int B_BUSY   = 0;

    typedef struct packed {
        logic frame;
        logic ovr;
        logic par;
        logic brk;
        logic err;
        logic addr;
        logic unread;
    } rx_flags_t;
endpackage

// File: rtl/usts_flag_core.sv
module usts_flag_core
    import usts_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      char_done,
    input  logic      frame_err,
    input  logic      par_err,
    input  logic      brk_det,
    input  logic      addr_idle,
    input  logic      par_en,
    input  logic      mp_addr,
    input  logic      rd_buf,
    input  logic      sw_reset,
    output rx_flags_t flags_q
);
    rx_flags_t flags_d;
    logic      overrun_now;
    logic      par_hit;

    always_comb begin
        flags_d     = flags_q;
        par_hit     = par_err & par_en;
        overrun_now = char_done & flags_q.unread & ~rd_buf;

        if (rd_buf) begin
            flags_d = '0;
        end

        if (char_done) begin
            flags_d.unread = 1'b1;
            if (frame_err)  flags_d.frame = 1'b1;
            if (par_hit)    flags_d.par   = 1'b1;
            if (brk_det)    flags_d.brk   = 1'b1;
            if (overrun_now) flags_d.ovr  = 1'b1;
            if (frame_err | par_hit | overrun_now) flags_d.err = 1'b1;
            if (mp_addr & addr_idle) flags_d.addr = 1'b1;
        end

        if (!mp_addr && addr_idle) begin
            flags_d.addr = 1'b1;
        end

        if (sw_reset) begin
            flags_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/usts_loop_ctrl.sv
module usts_loop_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_loop,
    input  logic sw_reset,
    output logic loop_q
);
    logic loop_d;

    always_comb begin
        loop_d = loop_q;
        if (wr_en && sw_reset) loop_d = wr_loop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loop_q <= 1'b0;
        else        loop_q <= loop_d;
    end
endmodule

// File: rtl/usts_stat_pack.sv
module usts_stat_pack
    import usts_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  rx_flags_t   flags,
    input  logic        loop_on,
    input  logic        par_en,
    input  logic        busy,
    output logic [W-1:0] word
);
    localparam int RSV_N = W - LOW_W;

    always_comb begin
        word[B_LOOP]  = loop_on;
        word[B_FRAME] = flags.frame;
        word[B_OVR]   = flags.ovr;
        word[B_PAR]   = flags.par & par_en;
        word[B_BRK]   = flags.brk;
        word[B_ERR]   = flags.err;
        word[B_ADDR]  = flags.addr;
        word[B_BUSY]  = busy;
    end

    for (genvar i = 0; i < RSV_N; i++) begin : g_rsv
        assign word[LOW_W + i] = 1'b0;
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import usts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic              frame_err,
    input  logic              par_err,
    input  logic              brk_det,
    input  logic              addr_idle,
    input  logic              par_en,
    input  logic              mp_addr,
    input  logic              rd_buf,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic              sw_reset,
    input  logic              wr_en,
    input  logic              wr_loop,
    input  logic              tx_line,
    input  logic              rx_pin,
    output logic [STAT_W-1:0] status,
    output logic              loop_en,
    output logic              rx_line
);
    rx_flags_t flags;
    logic      loop_q;
    logic      busy_any;

    usts_flag_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_done (char_done),
        .frame_err (frame_err),
        .par_err   (par_err),
        .brk_det   (brk_det),
        .addr_idle (addr_idle),
        .par_en    (par_en),
        .mp_addr   (mp_addr),
        .rd_buf    (rd_buf),
        .sw_reset  (sw_reset),
        .flags_q   (flags)
    );

    usts_loop_ctrl u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_loop  (wr_loop),
        .sw_reset (sw_reset),
        .loop_q   (loop_q)
    );

    assign busy_any = tx_busy | rx_busy;

    usts_stat_pack #(.W(STAT_W)) u_pack (
        .flags   (flags),
        .loop_on (loop_q),
        .par_en  (par_en),
        .busy    (busy_any),
        .word    (status)
    );

    assign loop_en = loop_q;
    assign rx_line = loop_q ? tx_line : rx_pin;
endmodule

// File: rtl/usts_checker.sv
module usts_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        char_done,
    input logic        frame_err,
    input logic        addr_idle,
    input logic        par_en,
    input logic        rd_buf,
    input logic        sw_reset,
    input logic [15:0] status,
    input logic        loop_en
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) status[15:8] == 8'h00); // R2
    AST_LOOP_LOCK: assert property (@(posedge clk) disable iff (!rst_n) !sw_reset |=> $stable(loop_en)); // R4
    AST_PAR_MASK: assert property (@(posedge clk) disable iff (!rst_n) !par_en |-> !status[4]); // R8
    AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n) (char_done && frame_err && !sw_reset) |=> (status[6] && status[2])); // R6 R10
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[5]) |-> $past(char_done)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_buf && !char_done && !addr_idle) |=> status[6:1] == 6'h00); // R12
    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sw_reset |=> status[6:1] == 6'h00); // R13
endmodule

bind uart_rx_status usts_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_done (char_done),
    .frame_err (frame_err),
    .addr_idle (addr_idle),
    .par_en    (par_en),
    .rd_buf    (rd_buf),
    .sw_reset  (sw_reset),
    .status    (status),
    .loop_en   (loop_en)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic char_done = 0, frame_err = 0, par_err = 0, brk_det = 0, addr_idle = 0;
    logic par_en = 0, mp_addr = 0, rd_buf = 0, tx_busy = 0, rx_busy = 0;
    logic sw_reset = 0, wr_en = 0, wr_loop = 0, tx_line = 0, rx_pin = 0;
    logic [15:0] status;
    logic loop_en, rx_line;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit m_fe, m_oe, m_pe, m_brk, m_err, m_ai, m_unread, m_lb;
    bit ctx_rd, ctx_sw;

    always #2 clk = ~clk;

    uart_rx_status dut (
        .clk(clk), .rst_n(rst_n), .char_done(char_done), .frame_err(frame_err),
        .par_err(par_err), .brk_det(brk_det), .addr_idle(addr_idle), .par_en(par_en),
        .mp_addr(mp_addr), .rd_buf(rd_buf), .tx_busy(tx_busy), .rx_busy(rx_busy),
        .sw_reset(sw_reset), .wr_en(wr_en), .wr_loop(wr_loop), .tx_line(tx_line),
        .rx_pin(rx_pin), .status(status), .loop_en(loop_en), .rx_line(rx_line)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag(input string base);
        if (ctx_sw) return {base, "/R13"};
        if (ctx_rd) return {base, "/R12"};
        return base;
    endfunction

    task automatic compare_all();
        chk("R2 reserved", {8'h0, status[15:8]}, 16'h0);
        chk("R4 loop bit", {15'h0, status[7]}, {15'h0, m_lb});
        chk("R4 loop port", {15'h0, loop_en}, {15'h0, m_lb});
        chk("R5 rx_line", {15'h0, rx_line}, {15'h0, m_lb ? tx_line : rx_pin});
        chk(tag("R6 frame"), {15'h0, status[6]}, {15'h0, m_fe});
        chk(tag("R7 overrun"), {15'h0, status[5]}, {15'h0, m_oe});
        chk(tag("R8 parity"), {15'h0, status[4]}, {15'h0, m_pe && par_en});
        chk(tag("R9 break"), {15'h0, status[3]}, {15'h0, m_brk});
        chk(tag("R10 rxerr"), {15'h0, status[2]}, {15'h0, m_err});
        chk(tag("R11 addr_idle"), {15'h0, status[1]}, {15'h0, m_ai});
        chk("R3 busy", {15'h0, status[0]}, {15'h0, tx_busy || rx_busy});
    endtask

    // Model next state: written as read-then-events sequence
    task automatic model_step();
        bit lost;
        ctx_rd = rd_buf;
        ctx_sw = sw_reset;
        if (sw_reset) begin
            {m_fe, m_oe, m_pe, m_brk, m_err, m_ai, m_unread} = '0;
            if (wr_en) m_lb = wr_loop;
            return;
        end
        lost = char_done && m_unread && !rd_buf;
        if (rd_buf) {m_fe, m_oe, m_pe, m_brk, m_err, m_ai, m_unread} = '0;
        if (char_done) begin
            m_unread = 1;
            m_fe  |= frame_err;
            m_pe  |= par_err && par_en;
            m_brk |= brk_det;
            m_oe  |= lost;
            m_err |= frame_err || (par_err && par_en) || lost;
            if (mp_addr) m_ai |= addr_idle;
        end
        if (!mp_addr) m_ai |= addr_idle;
    endtask

    task automatic cycle(input int p_char, input int p_rd, input int p_err,
                         input int p_sw, input bit pe, input bit mp);
        @(negedge clk);
        char_done = ($urandom_range(99) < p_char);
        frame_err = ($urandom_range(99) < p_err);
        par_err   = ($urandom_range(99) < p_err);
        brk_det   = ($urandom_range(99) < p_err);
        addr_idle = ($urandom_range(99) < p_err);
        rd_buf    = ($urandom_range(99) < p_rd);
        sw_reset  = ($urandom_range(99) < p_sw);
        wr_en     = ($urandom_range(99) < 20);
        wr_loop   = $urandom_range(1);
        tx_busy   = $urandom_range(1);
        rx_busy   = $urandom_range(1);
        tx_line   = $urandom_range(1);
        rx_pin    = $urandom_range(1);
        par_en    = ($urandom_range(99) < 85) ? pe : ~pe;
        mp_addr   = mp;
        #1;
        compare_all();
        model_step();
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        {m_fe, m_oe, m_pe, m_brk, m_err, m_ai, m_unread, m_lb} = '0;
        ctx_rd = 0;
        ctx_sw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 status after reset", status, 16'h0000);
        chk("R1 loop after reset", {15'h0, loop_en}, 16'h0);
        // R4: write without software reset is ignored
        wr_en = 1; wr_loop = 1; sw_reset = 0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 0;
        #1;
        chk("R4 write ignored", {15'h0, loop_en}, 16'h0);
        // random phases: rates, parity and mode vary
        for (int i = 0; i < 600; i++) cycle(30, 30, 20, 3, 1, 1);
        for (int i = 0; i < 600; i++) cycle(70, 10, 30, 2, 1, 0);
        for (int i = 0; i < 600; i++) cycle(60, 60, 40, 2, 0, 1);
        for (int i = 0; i < 600; i++) cycle(50, 50, 50, 15, 1, 0);
        for (int i = 0; i < 600; i++) cycle(90, 5, 10, 1, 0, 0);
        for (int i = 0; i < 600; i++) cycle(40, 80, 60, 5, 1, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule